// File: doc/BRIEF.md
# Flash Completion Poll Engine

This block runs on the host side of a NOR-style memory and decides when an embedded program or erase operation inside that memory has finished. After software or a sequencer has issued the program or erase command, a one-cycle start pulse hands the engine three things: a method select, the word that is expected to end up at the target location, and that location's address. The engine then issues read requests on an abstract request/acknowledge memory port and inspects the returned status bits. When it reaches a decision it returns a one-cycle done pulse with a two-bit verdict.

Two methods are offered. The first compares bit 7 of each read word against bit 7 of the expected word. The second reads twice in a row and checks whether bit 6 has stopped flipping. Both methods watch bit 5, the memory's internal time-limit flag. Bit 7 or bit 6 may settle in the very read where bit 5 rises. For that reason a raised bit 5 never fails the operation on its own: the engine always re-reads and judges again.

When the operation has failed, the engine writes the reset command word to the memory. This returns the memory to array-read mode. A programmable poll budget protects against a memory that never reaches a verdict.

Top module: `nor_done_poller`

## Requirements
- R1: After reset, busy_o, done_o and mem_req_o are 0 and result_o is 00.
- R2: With mode_i=0 (bit-7 method), every read goes to the latched address. A read whose bit 7 equals bit 7 of the expected word ends the run with result 00 (pass). This holds even if bit 5 of the same word is 1.
- R3: With mode_i=0, a read whose bit 7 differs from the expected bit 7 and whose bit 5 is 0 leads to another read of the same address.
- R4: With mode_i=0, a read whose bit 7 differs and whose bit 5 is 1 leads to exactly one confirming read. A bit-7 match on that read gives pass. A mismatch gives fail.
- R5: With mode_i=1 (bit-6 method), reads are taken in pairs. If bit 6 is equal in both reads of a pair, the run ends with pass.
- R6: With mode_i=1, if bit 6 differs within a pair and bit 5 of the second read is 0, a new pair is read.
- R7: With mode_i=1, if bit 6 differs within a pair and bit 5 of the second read is 1, two further reads follow. Bit 6 differing between them gives fail. Equal bit 6 gives pass.
- R8: Before a fail verdict, the engine makes exactly one write on the memory port (mem_we_o=1) with data 00F0h to the latched address. The done pulse with result 01 follows that write's acknowledge.
- R9: Every "keep polling" decision (R3, or R6 per pair) uses up one unit of the budget max_polls_i. When the decision that would need another poll finds the budget used up, the run ends with result 10 and no write is made. A budget of 0 behaves as 1. A raised bit 5 takes precedence over the budget.
- R10: While mem_req_o is high and mem_ack_i is low, mem_req_o, mem_we_o and mem_addr_o stay stable. mem_rdata_i is used only in a cycle with mem_ack_i high.
- R11: done_o is high for exactly one cycle. It rises in the cycle after the final acknowledge, with result_o holding 00 pass, 01 fail or 10 budget timeout.
- R12: A start pulse while busy_o is high is ignored. The running sequence, its address and its verdict are unchanged.
- R13: For an erase, where the expected word is FFFFh, a read with bit 7 equal to 1 counts as completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse, taken only while idle |
| mode_i | input | 1 | 0: bit-7 compare, 1: bit-6 flip detection |
| expect_i | input | DW (16) | Word expected at the target after the operation |
| addr_i | input | AW (21) | Target address used for all reads and the reset write |
| max_polls_i | input | CW (16) | Poll budget |
| mem_req_o | output | 1 | Memory access request, held until acknowledge |
| mem_we_o | output | 1 | 1 for the reset command write, 0 for reads |
| mem_addr_o | output | AW (21) | Access address |
| mem_wdata_o | output | DW (16) | Write data (00F0h) |
| mem_ack_i | input | 1 | Access acknowledge; read data valid with it |
| mem_rdata_i | input | DW (16) | Read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 2 | Verdict: 00 pass, 01 fail, 10 budget timeout |

## Verification
Two things can happen in the same read: the status bit settles (bit 7 matches, or bit 6 stops flipping) and bit 5 rises. A second coincidence is a raised bit 5 arriving just as the poll budget runs out.

The memory model in the bench returns scripted words, so both coincidences are provoked on purpose. One case returns a word where bit 7 matches and bit 5 is set together; it must pass after a single read. Other cases raise bit 5 with the budget already spent, or follow bit 5 with a settling or non-settling confirmation. Each run is judged by the scoreboard on the verdict and on the exact number of reads and writes.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic [1:0] {
    RES_PASS = 2'b00,
    RES_FAIL = 2'b01,
    RES_TMO  = 2'b10
  } poll_res_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DP,
    ST_DP_CONF,
    ST_TG_A,
    ST_TG_B,
    ST_TG_C,
    ST_TG_D,
    ST_RST,
    ST_FIN
  } poll_st_e;

  localparam logic [7:0] RESET_CMD = 8'hF0;
endpackage

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [CW-1:0] limit_i,
  input  logic          inc_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] lim_q, lim_d;
  logic [CW:0]   cnt_plus;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (clr_i) begin
      cnt_d = '0;
      lim_d = limit_i;
    end else if (inc_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  // the decision being made now would be poll number cnt+1
  assign cnt_plus = {1'b0, cnt_q} + 1'b1;
  assign last_o   = (cnt_plus >= {1'b0, lim_q});

  p_cnt_within_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i && !clr_i |-> !last_o);
endmodule

// File: rtl/poll_judge.sv
module poll_judge (
  input  logic b7_i,
  input  logic b6_i,
  input  logic b5_i,
  input  logic exp7_i,
  input  logic prev6_i,
  output logic dp_match_o,
  output logic tg_same_o,
  output logic limit_flag_o
);
  assign dp_match_o   = (b7_i == exp7_i);
  assign tg_same_o    = (b6_i == prev6_i);
  assign limit_flag_o = b5_i;
endmodule

// File: rtl/poll_fsm.sv
module poll_fsm
  import poll_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic          exp7_i,
  input  logic [AW-1:0] addr_i,
  input  logic          mem_ack_i,
  input  logic          rd6_i,
  input  logic          dp_match_i,
  input  logic          tg_same_i,
  input  logic          flag5_i,
  input  logic          budget_last_i,
  output logic          budget_clr_o,
  output logic          budget_inc_o,
  output logic          exp7_o,
  output logic          prev6_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o
);
  poll_st_e      st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          exp7_q, exp7_d;
  logic          prev6_q, prev6_d;
  poll_res_e     res_q, res_d;

  always_comb begin
    st_d         = st_q;
    addr_d       = addr_q;
    exp7_d       = exp7_q;
    prev6_d      = prev6_q;
    res_d        = res_q;
    budget_clr_o = 1'b0;
    budget_inc_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        addr_d       = addr_i;
        exp7_d       = exp7_i;
        budget_clr_o = 1'b1;
        st_d         = mode_i ? ST_TG_A : ST_DP;
      end
      ST_DP: if (mem_ack_i) begin
        if (dp_match_i) begin
          res_d = RES_PASS; st_d = ST_FIN;
        end else if (flag5_i) begin
          st_d = ST_DP_CONF;
        end else if (budget_last_i) begin
          res_d = RES_TMO; st_d = ST_FIN;
        end else begin
          budget_inc_o = 1'b1;
        end
      end
      ST_DP_CONF: if (mem_ack_i) begin
        if (dp_match_i) begin
          res_d = RES_PASS; st_d = ST_FIN;
        end else begin
          st_d = ST_RST;
        end
      end
      ST_TG_A: if (mem_ack_i) begin
        prev6_d = rd6_i; st_d = ST_TG_B;
      end
      ST_TG_B: if (mem_ack_i) begin
        if (tg_same_i) begin
          res_d = RES_PASS; st_d = ST_FIN;
        end else if (flag5_i) begin
          st_d = ST_TG_C;
        end else if (budget_last_i) begin
          res_d = RES_TMO; st_d = ST_FIN;
        end else begin
          budget_inc_o = 1'b1; st_d = ST_TG_A;
        end
      end
      ST_TG_C: if (mem_ack_i) begin
        prev6_d = rd6_i; st_d = ST_TG_D;
      end
      ST_TG_D: if (mem_ack_i) begin
        if (tg_same_i) begin
          res_d = RES_PASS; st_d = ST_FIN;
        end else begin
          st_d = ST_RST;
        end
      end
      ST_RST: if (mem_ack_i) begin
        res_d = RES_FAIL; st_d = ST_FIN;
      end
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      exp7_q  <= 1'b0;
      prev6_q <= 1'b0;
      res_q   <= RES_PASS;
    end else begin
      st_q    <= st_d;
      addr_q  <= addr_d;
      exp7_q  <= exp7_d;
      prev6_q <= prev6_d;
      res_q   <= res_d;
    end
  end

  assign exp7_o      = exp7_q;
  assign prev6_o     = prev6_q;
  assign mem_we_o    = (st_q == ST_RST);
  assign mem_req_o   = (st_q != ST_IDLE) && (st_q != ST_FIN);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = {{(DW-8){1'b0}}, RESET_CMD};
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
  assign result_o    = res_q;

  p_hold_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_fail_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (result_o == RES_FAIL) |-> $past(mem_ack_i && mem_we_o));
  p_no_write_else_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (result_o != RES_FAIL) |-> !$past(mem_we_o));
  p_start_takes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o && mem_req_o);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o && !done_o);
endmodule

// File: rtl/nor_done_poller.sv
module nor_done_poller #(
  parameter int DW = 16,
  parameter int AW = 21,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [DW-1:0] expect_i,
  input  logic [AW-1:0] addr_i,
  input  logic [CW-1:0] max_polls_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [1:0]    result_o
);
  localparam int B7 = 7;
  localparam int B6 = 6;
  localparam int B5 = 5;

  logic b_clr, b_inc, b_last;
  logic exp7_q, prev6_q;
  logic dp_match, tg_same, flag5;

  poll_judge i_judge (
    .b7_i        (mem_rdata_i[B7]),
    .b6_i        (mem_rdata_i[B6]),
    .b5_i        (mem_rdata_i[B5]),
    .exp7_i      (exp7_q),
    .prev6_i     (prev6_q),
    .dp_match_o  (dp_match),
    .tg_same_o   (tg_same),
    .limit_flag_o(flag5)
  );

  poll_budget #(.CW(CW)) i_budget (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (b_clr),
    .limit_i(max_polls_i),
    .inc_i  (b_inc),
    .last_o (b_last)
  );

  poll_fsm #(.DW(DW), .AW(AW)) i_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .mode_i       (mode_i),
    .exp7_i       (expect_i[B7]),
    .addr_i       (addr_i),
    .mem_ack_i    (mem_ack_i),
    .rd6_i        (mem_rdata_i[B6]),
    .dp_match_i   (dp_match),
    .tg_same_i    (tg_same),
    .flag5_i      (flag5),
    .budget_last_i(b_last),
    .budget_clr_o (b_clr),
    .budget_inc_o (b_inc),
    .exp7_o       (exp7_q),
    .prev6_o      (prev6_q),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .result_o     (result_o)
  );
endmodule

// File: tb/test_nor_done_poller.sv
module test_nor_done_poller;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        mode_i = 1'b0;
  logic [15:0] expect_i = '0;
  logic [20:0] addr_i = '0;
  logic [15:0] max_polls_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [20:0] mem_addr_o;
  logic [15:0] mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [15:0] mem_rdata_i = 16'hA5A5;
  logic        busy_o, done_o;
  logic [1:0]  result_o;

  always #4 clk = ~clk;

  nor_done_poller i_nor_done_poller (.*);

  typedef struct {
    logic [1:0] res;
    int rd; int wr;
    int rd0; int wr0; int bad0;
    string tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [15:0] rsp_q[$];
  int checks = 0, errors = 0;
  int lat = 0, wait_cnt = 0;
  int n_rd = 0, n_wr = 0, addr_bad = 0;
  int cyc = 0, last_ack = 0;
  logic [20:0] case_addr = '0;
  logic [15:0] last_wd = '0;
  logic prev_done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: scripted read words, junk data outside acknowledge cycles (R10)
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_ack_i) last_ack <= cyc;
    if (mem_req_o && !mem_ack_i) begin
      if (mem_addr_o != case_addr) addr_bad <= addr_bad + 1;
      if (wait_cnt >= lat) begin
        mem_ack_i <= 1'b1;
        wait_cnt  <= 0;
        if (mem_we_o) begin
          n_wr        <= n_wr + 1;
          last_wd     <= mem_wdata_o;
          mem_rdata_i <= 16'hA5A5;
        end else begin
          n_rd        <= n_rd + 1;
          mem_rdata_i <= (rsp_q.size() > 0) ? rsp_q.pop_front() : 16'h0000;
        end
      end else begin
        wait_cnt    <= wait_cnt + 1;
        mem_ack_i   <= 1'b0;
        mem_rdata_i <= 16'hA5A5;
      end
    end else begin
      mem_ack_i   <= 1'b0;
      mem_rdata_i <= 16'hA5A5;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        chk(!prev_done, "R11 done width", 1, 0);
        chk(cyc == last_ack + 1, "R11 done timing", cyc, last_ack + 1);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R11 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(result_o == e.res, {e.tag, " result"}, result_o, e.res);
          chk(n_rd - e.rd0 == e.rd, {e.tag, " reads"}, n_rd - e.rd0, e.rd);
          chk(n_wr - e.wr0 == e.wr, {e.tag, " R8 writes"}, n_wr - e.wr0, e.wr);
          chk(addr_bad == e.bad0, {e.tag, " R10 address"}, addr_bad, e.bad0);
          if (e.wr != 0) chk(last_wd == 16'h00F0, {e.tag, " R8 data"}, last_wd, 16'h00F0);
        end
      end
      prev_done <= done_o;
    end
  end

  task automatic run_case(input bit mode, input logic [15:0] expw, input logic [20:0] a,
                          input int maxp, input int l, input logic [1:0] xres,
                          input int xrd, input int xwr, input bit restart, input string tag);
    exp_t e;
    @(negedge clk);
    lat = l;
    case_addr = a;
    e.res = xres; e.rd = xrd; e.wr = xwr;
    e.rd0 = n_rd; e.wr0 = n_wr; e.bad0 = addr_bad; e.tag = tag;
    sb_q.push_back(e);
    mode_i = mode; expect_i = expw; addr_i = a; max_polls_i = maxp[15:0];
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (restart) begin
      repeat (2) @(negedge clk);
      mode_i = ~mode; addr_i = ~a; expect_i = ~expw; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    @(negedge clk);
    chk(!busy_o, {tag, " idle after done"}, busy_o, 0);
    chk(rsp_q.size() == 0, {tag, " all words consumed"}, rsp_q.size(), 0);
    rsp_q.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy_o && !done_o && !mem_req_o, "R1 idle at reset", {busy_o, done_o, mem_req_o}, 0);
    chk(result_o == 2'b00, "R1 result at reset", result_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !mem_req_o, "R1 idle after release", {busy_o, mem_req_o}, 0);

    rsp_q = '{16'h0080};
    run_case(0, 16'h0080, 21'h012345, 8, 0, 2'b00, 1, 0, 0, "R2 first read match");
    rsp_q = '{16'h0000, 16'h0000, 16'h0081};
    run_case(0, 16'h00FF, 21'h000AAA, 8, 2, 2'b00, 3, 0, 1, "R3 R12 keep polling, restart ignored");
    rsp_q = '{16'h0020, 16'h0080};
    run_case(0, 16'h0080, 21'h1F0001, 8, 1, 2'b00, 2, 0, 0, "R4 confirm pass");
    rsp_q = '{16'h0020, 16'h0020};
    run_case(0, 16'h0080, 21'h100000, 8, 0, 2'b01, 2, 1, 0, "R4 R8 confirm fail");
    rsp_q = '{16'h00A0};
    run_case(0, 16'h0080, 21'h000010, 8, 3, 2'b00, 1, 0, 0, "R2 match with bit5 same read");
    rsp_q = '{16'h0000, 16'hFFFF};
    run_case(0, 16'hFFFF, 21'h0ABCDE, 8, 0, 2'b00, 2, 0, 0, "R13 erase");
    rsp_q = '{16'h0040, 16'h0040};
    run_case(1, 16'h0000, 21'h000555, 8, 0, 2'b00, 2, 0, 0, "R5 toggle stopped");
    rsp_q = '{16'h0000, 16'h0040, 16'h0040, 16'h0000, 16'h0000, 16'h0000};
    run_case(1, 16'h0000, 21'h0002AA, 8, 1, 2'b00, 6, 0, 0, "R6 repeated pairs");
    rsp_q = '{16'h0000, 16'h0060, 16'h0000, 16'h0040};
    run_case(1, 16'h0000, 21'h1ABCD0, 8, 2, 2'b01, 4, 1, 0, "R7 R8 toggle fail");
    rsp_q = '{16'h0000, 16'h0060, 16'h0040, 16'h0040};
    run_case(1, 16'h0000, 21'h001234, 1, 0, 2'b00, 4, 0, 0, "R7 toggle confirm pass, bit5 over budget");
    rsp_q = '{16'h0000, 16'h0000, 16'h0000};
    run_case(0, 16'h0080, 21'h003333, 3, 0, 2'b10, 3, 0, 0, "R9 budget three");
    rsp_q = '{16'h0000};
    run_case(0, 16'h0080, 21'h004444, 0, 1, 2'b10, 1, 0, 0, "R9 budget zero");
    rsp_q = '{16'h0000, 16'h0040, 16'h0000, 16'h0040};
    run_case(1, 16'h0000, 21'h005555, 2, 0, 2'b10, 4, 0, 0, "R9 toggle budget");

    chk(sb_q.size() == 0, "R11 every run completed", sb_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule